// File: doc/BRIEF.md
# Programmed-I/O Transmit Queue Register Port

This block is the device side of one transmit queue in a multi-queue programmed-I/O interface. A host writes a 16-bit control register and a 16-bit data register inside a 16-byte window. The control register arms the byte lanes, opens and closes frames and suspends the queue. Each accepted data write pushes one or two bytes into the transmit path. The output is a two-lane byte stream with start and end markers. The low lane, bits [7:0], is the earlier byte in stream order. A read-only register in the window reports the internal buffer capacity.

A parameter selects one of two write orderings. In normal ordering the lane bits are written first and every data write after them is emitted at once. In legacy ordering each data write waits in a one-deep holding register. It is released by the next data write, using the current lanes, or by a control write that carries lane bits. This lets the final byte of a frame travel together with the frame-complete command. Four copies of the block at bases 0x300, 0x310, 0x320 and 0x330 make up a full interface. Address decode above the window sits outside this block.

Top module: `pioTxPort`

## Requirements
- R1: After reset, outLaneValid, outData, outSof, outEof, suspended and errFlag are all zero.
- R2: Reads are combinational on hostAddr. Offset 0x4 returns the BUF_SIZE parameter. Offset 0x0 returns the suspend bit in bit 7 and the lane enables in bits [1:0]. Offsets 0x2, 0x6, 0xC and 0xE return zero.
- R3: In normal ordering, a data write at offset 0x2 while a frame is open and the queue is not suspended appears on the cycle after the write. outLaneValid equals control bits [1:0] (bit 0 = low byte, bit 1 = high byte, 3 = halfword). outData carries the enabled bytes and zero in the disabled lanes.
- R4: A control write with bit 3 set (0x08) opens a new frame. The first later beat that carries bytes has outSof high. Later beats have outSof low.
- R5: In normal ordering, a control write with bit 2 set (0x04) to an open frame gives a one-cycle outEof with no lanes valid and closes the frame.
- R6: In legacy ordering, a data write emits nothing by itself when the holding register is empty. The next control write with nonzero bits [1:0] releases the held data on those lanes.
- R7: In legacy ordering, a data write that finds the holding register full releases the held halfword on the current lanes and takes its place.
- R8: In legacy ordering, control value 0x05 releases the held byte on the low lane with outEof high in the same cycle and closes the frame.
- R9: A control write with bit 7 set (0x80) raises suspended. Data writes while suspended produce no output and set errFlag. A control write with bit 7 clear resumes the queue.
- R10: A data write with no frame open produces no output and sets errFlag. errFlag stays set until reset.
- R11: A complete command while no frame is open produces no outEof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Register write strobe |
| hostAddr | input | 4 | Byte offset within the queue window |
| hostWrData | input | 16 | Write data |
| hostRdData | output | 16 | Read data for hostAddr |
| outLaneValid | output | 2 | Byte lanes valid this cycle, bit 0 = earlier byte |
| outData | output | 16 | Stream bytes, disabled lanes zero |
| outSof | output | 1 | First bytes of a frame |
| outEof | output | 1 | Frame end |
| suspended | output | 1 | Queue suspended |
| errFlag | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds two copies of the block side by side. One uses normal ordering with BUF_SIZE 1024. The other uses legacy ordering with BUF_SIZE 2048, so that the capacity readback is seen to follow the parameter. The normal copy walks a vector table covering lane selection, start and end markers, and dropped writes. The legacy copy runs directed sequences that show the one-deep hold released by a data write and by a control write, including the final byte leaving with the complete command. A suspend sequence on the legacy copy, which starts with errFlag still clear, shows that a suspended write is what sets the error.

// File: rtl/pioTxPkg.sv
package pioTxPkg;
  localparam int WIN_ADDR_W = 4;
  localparam int DATA_W     = 16;
  localparam int LANES      = DATA_W / 8;

  localparam logic [WIN_ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [WIN_ADDR_W-1:0] OFS_DATA = 4'h2;
  localparam logic [WIN_ADDR_W-1:0] OFS_SIZE = 4'h4;

  localparam int BIT_DONE    = 2;
  localparam int BIT_START   = 3;
  localparam int BIT_SUSPEND = 7;

  typedef struct packed {
    logic             loadHold;
    logic             emitHold;
    logic             emitDirect;
    logic             clearHold;
    logic [LANES-1:0] lanes;
    logic             sof;
    logic             eof;
  } pioStrobe_t;
endpackage

// File: rtl/pioTxCtrl.sv
module pioTxCtrl
  import pioTxPkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWrEn,
  input  logic [WIN_ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]     hostWrData,
  input  logic                  holdValid,
  output pioStrobe_t            strobe,
  output logic                  suspended,
  output logic [LANES-1:0]      laneEn,
  output logic                  errFlag
);
  logic ctrlWr, dataWr, accept;
  logic frameOpen, sofPending;
  logic [LANES-1:0] newLanes;

  assign ctrlWr   = hostWrEn && (hostAddr == OFS_CTRL);
  assign dataWr   = hostWrEn && (hostAddr == OFS_DATA);
  assign accept   = frameOpen && !suspended;
  assign newLanes = hostWrData[LANES-1:0];

  always_comb begin
    strobe = '0;
    if (dataWr && accept) begin
      if (LEGACY) begin
        strobe.loadHold = 1'b1;
        if (holdValid) begin
          strobe.emitHold = 1'b1;
          strobe.lanes    = laneEn;
        end
      end else begin
        strobe.emitDirect = 1'b1;
        strobe.lanes      = laneEn;
      end
    end
    if (ctrlWr) begin
      if (hostWrData[BIT_START]) begin
        strobe.clearHold = 1'b1;
      end else if (frameOpen && !hostWrData[BIT_SUSPEND]) begin
        if (LEGACY && holdValid && (newLanes != '0)) begin
          strobe.emitHold  = 1'b1;
          strobe.lanes     = newLanes;
          strobe.clearHold = 1'b1;
        end
        if (hostWrData[BIT_DONE]) begin
          strobe.eof       = 1'b1;
          strobe.clearHold = 1'b1;
        end
      end
    end
    strobe.sof = sofPending && (strobe.lanes != '0) &&
                 (strobe.emitHold || strobe.emitDirect);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspended  <= 1'b0;
      laneEn     <= '0;
      frameOpen  <= 1'b0;
      sofPending <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      if (ctrlWr) begin
        suspended <= hostWrData[BIT_SUSPEND];
        laneEn    <= newLanes;
      end
      if (ctrlWr && hostWrData[BIT_START]) begin
        frameOpen  <= 1'b1;
        sofPending <= 1'b1;
      end else begin
        if (strobe.eof) frameOpen <= 1'b0;
        if (strobe.sof) sofPending <= 1'b0;
      end
      if (dataWr && !accept) errFlag <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R10
  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !frameOpen) |=> errFlag); // R10
  AST_EOF_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eof |-> frameOpen); // R11
endmodule

// File: rtl/pioTxData.sv
module pioTxData
  import pioTxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobe_t        strobe,
  input  logic [DATA_W-1:0] hostWrData,
  output logic              holdValid,
  output logic [LANES-1:0]  outLaneValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSof,
  output logic              outEof
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] srcData;
  logic              emitAny;

  assign emitAny = strobe.emitDirect || strobe.emitHold;
  assign srcData = strobe.emitHold ? holdReg : hostWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else if (strobe.loadHold) begin
      holdReg   <= hostWrData;
      holdValid <= 1'b1;
    end else if (strobe.clearHold) begin
      holdValid <= 1'b0;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outLaneValid[i]    <= 1'b0;
        outData[8*i +: 8]  <= '0;
      end else begin
        outLaneValid[i]    <= emitAny && strobe.lanes[i];
        outData[8*i +: 8]  <= (emitAny && strobe.lanes[i]) ? srcData[8*i +: 8] : 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSof <= 1'b0;
      outEof <= 1'b0;
    end else begin
      outSof <= strobe.sof;
      outEof <= strobe.eof;
    end
  end

  AST_SOF_WITH_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> (outLaneValid != '0)); // R4
  AST_HOLD_ONE_DEEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitHold |-> holdValid); // R7
endmodule

// File: rtl/pioTxPort.sv
module pioTxPort
  import pioTxPkg::*;
#(
  parameter bit          LEGACY   = 1'b0,
  parameter logic [15:0] BUF_SIZE = 16'd1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [3:0]  hostAddr,
  input  logic [15:0] hostWrData,
  output logic [15:0] hostRdData,
  output logic [1:0]  outLaneValid,
  output logic [15:0] outData,
  output logic        outSof,
  output logic        outEof,
  output logic        suspended,
  output logic        errFlag
);
  pioStrobe_t       strobe;
  logic             holdValid;
  logic [LANES-1:0] laneEn;

  pioTxCtrl #(.LEGACY(LEGACY)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .holdValid(holdValid), .strobe(strobe),
    .suspended(suspended), .laneEn(laneEn), .errFlag(errFlag)
  );

  pioTxData u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrData(hostWrData),
    .holdValid(holdValid), .outLaneValid(outLaneValid), .outData(outData),
    .outSof(outSof), .outEof(outEof)
  );

  always_comb begin
    hostRdData = '0;
    if (hostAddr == OFS_SIZE) begin
      hostRdData = BUF_SIZE;
    end else if (hostAddr == OFS_CTRL) begin
      hostRdData[BIT_SUSPEND]  = suspended;
      hostRdData[LANES-1:0]    = laneEn;
    end
  end

  AST_SUSP_NO_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (suspended && !(hostWrEn && hostAddr == OFS_CTRL)) |=> (outLaneValid == '0)); // R9
endmodule

// File: tb/pioTxPort_tb.sv
module pioTxPort_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrN = 1'b0, wrL = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdN, rdL, dataN, dataL;
  logic [1:0]  lvN, lvL;
  logic        sofN, sofL, eofN, eofL, suspN, suspL, errN, errL;
  int          nTests = 0, nFail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pioTxPort #(.LEGACY(1'b0), .BUF_SIZE(16'd1024)) u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(wrN), .hostAddr(addr), .hostWrData(wdata),
    .hostRdData(rdN), .outLaneValid(lvN), .outData(dataN), .outSof(sofN),
    .outEof(eofN), .suspended(suspN), .errFlag(errN));

  pioTxPort #(.LEGACY(1'b1), .BUF_SIZE(16'd2048)) u_dutLegacy (
    .clk(clk), .rstN(rstN), .hostWrEn(wrL), .hostAddr(addr), .hostWrData(wdata),
    .hostRdData(rdL), .outLaneValid(lvL), .outData(dataL), .outSof(sofL),
    .outEof(eofL), .suspended(suspL), .errFlag(errL));

  // {isCtrl, wdata, expLanes, expData, expSof, expEof, expErr}
  localparam logic [37:0] VEC [0:11] = '{
    {1'b1, 16'h0008, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0},  // R4 open
    {1'b1, 16'h0003, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b0, 16'hBEEF, 2'd3, 16'hBEEF, 1'b1, 1'b0, 1'b0},  // R3 R4
    {1'b0, 16'h1234, 2'd3, 16'h1234, 1'b0, 1'b0, 1'b0},  // R3
    {1'b1, 16'h0001, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b0, 16'hAB77, 2'd1, 16'h0077, 1'b0, 1'b0, 1'b0},  // R3 low lane
    {1'b1, 16'h0002, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b0, 16'h5500, 2'd2, 16'h5500, 1'b0, 1'b0, 1'b0},  // R3 high lane
    {1'b1, 16'h0004, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0},  // R5
    {1'b0, 16'h9999, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1},  // R10
    {1'b1, 16'h0004, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1},  // R11
    {1'b1, 16'h0009, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1}   // R4 reopen
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit legacy, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (legacy) wrL = 1'b1; else wrN = 1'b1;
    @(negedge clk);
    wrL = 1'b0; wrN = 1'b0;
  endtask

  task automatic chkN(input string req, input logic [1:0] lv, input logic [15:0] d,
                      input logic s, input logic e);
    chk(req, {lvN, dataN, sofN, eofN}, {lv, d, s, e});
  endtask

  task automatic chkL(input string req, input logic [1:0] lv, input logic [15:0] d,
                      input logic s, input logic e);
    chk(req, {lvL, dataL, sofL, eofL}, {lv, d, s, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {lvN, dataN, sofN, eofN, suspN, errN}, '0);
    chk("R1 reset legacy", {lvL, dataL, sofL, eofL, suspL, errL}, '0);
    rstN = 1'b1;
    @(negedge clk);

    addr = 4'h4; #1;
    chk("R2 size normal", rdN, 16'd1024);
    chk("R2 size legacy", rdL, 16'd2048);
    for (int a = 0; a < 4; a++) begin
      addr = (a == 0) ? 4'h2 : (a == 1) ? 4'h6 : (a == 2) ? 4'hC : 4'hE; #1;
      chk("R2 zero offset", rdN, 16'h0);
    end

    for (int i = 0; i < 12; i++) begin
      wr(1'b0, VEC[i][37] ? 4'h0 : 4'h2, VEC[i][36:21]);
      chkN("R3/R4/R5/R11 vector", VEC[i][20:19], VEC[i][18:3], VEC[i][2], VEC[i][1]);
      chk("R10 err vector", errN, VEC[i][0]);
    end

    // R9: suspend on normal copy, frame open with lane 0 armed
    wr(1'b0, 4'h0, 16'h0081);
    chk("R9 suspended", suspN, 1'b1);
    addr = 4'h0; #1;
    chk("R2 ctrl readback", rdN, 16'h0081);
    wr(1'b0, 4'h2, 16'h00AA);
    chkN("R9 drop while suspended", 2'd0, 16'h0, 1'b0, 1'b0);
    wr(1'b0, 4'h0, 16'h0001);
    chk("R9 resumed", suspN, 1'b0);
    wr(1'b0, 4'h2, 16'h33BB);
    chkN("R9 R4 after resume", 2'd1, 16'h00BB, 1'b1, 1'b0);

    // Legacy ordering
    wr(1'b1, 4'h0, 16'h0008);
    wr(1'b1, 4'h2, 16'h1111);
    chkL("R6 data held", 2'd0, 16'h0, 1'b0, 1'b0);
    wr(1'b1, 4'h0, 16'h0003);
    chkL("R6 commit by ctrl", 2'd3, 16'h1111, 1'b1, 1'b0);
    wr(1'b1, 4'h2, 16'h2222);
    chkL("R6 held again", 2'd0, 16'h0, 1'b0, 1'b0);
    wr(1'b1, 4'h2, 16'h3333);
    chkL("R7 release prior", 2'd3, 16'h2222, 1'b0, 1'b0);
    wr(1'b1, 4'h2, 16'hEE44);
    chkL("R7 release prior 2", 2'd3, 16'h3333, 1'b0, 1'b0);
    wr(1'b1, 4'h0, 16'h0005);
    chkL("R8 last byte with end", 2'd1, 16'h0044, 1'b0, 1'b1);
    wr(1'b1, 4'h0, 16'h0004);
    chkL("R11 no end when closed", 2'd0, 16'h0, 1'b0, 1'b0);
    wr(1'b1, 4'h0, 16'h0008);
    wr(1'b1, 4'h2, 16'h0055);
    wr(1'b1, 4'h0, 16'h0001);
    chkL("R6 single byte commit", 2'd1, 16'h0055, 1'b1, 1'b0);

    // R9 on legacy copy: error set by a suspended write
    chk("R9 err clear before", errL, 1'b0);
    wr(1'b1, 4'h0, 16'h0083);
    chk("R9 legacy suspended", suspL, 1'b1);
    wr(1'b1, 4'h2, 16'h7777);
    chkL("R9 legacy drop", 2'd0, 16'h0, 1'b0, 1'b0);
    chk("R9 legacy err set", errL, 1'b1);
    wr(1'b1, 4'h0, 16'h0003);
    chkL("R9 nothing held after drop", 2'd0, 16'h0, 1'b0, 1'b0);
    wr(1'b1, 4'h0, 16'h0004);
    chkL("R5 end on legacy", 2'd0, 16'h0, 1'b0, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule